// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Mode

This block is a time-of-day and calendar counter. Every field is kept in packed BCD: hundredths of a second, seconds, minutes, hours, day of week, date, month and a two-digit year. A single-cycle strobe at 100 Hz advances the count. The carry ripples through all eight fields within that same clock edge. Month ends follow the calendar, so short months and leap-year Februaries are handled.

The eight registers form one 64-bit image. An external access unit reads the image continuously as a snapshot. It replaces the whole image at once by pulsing a load strobe. The hours register selects the hour format: either a 12-hour count with an afternoon flag, or a 24-hour count. A stop bit in the day register freezes the count while it is set.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the image reads 64'h00_01_01_21_00_00_00_00. That is year 00, month 01, date 01, day 1 with the stop bit set, and 00:00:00.00 in 24-hour format.
- R2: Register k occupies image bits [8k+7:8k]. The registers are: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year.
  - When load is high at a clock edge, the image after that edge equals load_img ANDed with 64'hFF_1F_3F_27_BF_7F_7F_FF, so unused bits read 0.
  - Load takes priority over a tick in the same cycle.
- R3: Register 4 holds the day of week in bits 2:0 and the stop bit in bit 5.
  - With the stop bit at 0, each edge with tick high advances the hundredths by one.
  - With the stop bit at 1, or with tick low, the image does not change.
- R4: Hundredths wrap from 99 to 00 and carry into seconds. Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Without a carry, a higher field does not change.
- R5: With hours bit 7 at 0 (24-hour format), hours count 00 to 23, using bits 5:4 as the tens digit. On a carry, 23 wraps to 00 and advances the day of week and the date.
- R6: With hours bit 7 at 1 (12-hour format), bits 4:0 hold 01 to 12 and bit 5 is the afternoon flag (1 = PM).
  - The count runs 12, 01, ..., 11.
  - Passing from 11 to 12 toggles the flag.
  - Passing from 11 PM to 12 AM advances the day of week and the date.
  - Bit 7 is never changed by counting.
- R7: The day of week counts 1 to 7, and 7 wraps to 1.
- R8: Date wraps to 01 and advances the month after the last day of the month:
  - 30 for months 04, 06, 09 and 11;
  - 31 for months 01, 03, 05, 07, 08, 10 and 12;
  - 28 or 29 for month 02.
- R9: February ends on 29 when the year value is divisible by 4 (including 00), and on 28 otherwise.
- R10: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle 100 Hz advance strobe |
| load | input | 1 | Replace the whole image from load_img |
| load_img | input | 64 | New register image, register 0 in the low byte |
| img | output | 64 | Current register image, register 0 in the low byte |

## Verification
Some properties are checked on every cycle:
- the image stays frozen whenever neither a load nor an enabled tick occurs;
- a load lands as the masked image on the next edge;
- seconds stay put while hundredths are below 99;
- the hour-format bit is never changed by counting.

Other behaviour shows only in the bench's scenarios: the specific carry outcomes, namely the 12-hour sequence with its afternoon flag, each month length, the leap-year rule across decades, and year and weekday wrap-around. In those scenarios a known image is loaded, one tick is applied, and the whole image is compared.

// File: rtl/bcdcal_pkg.sv
// Package: shared widths, register layout constants and BCD helpers
// for the calendar clock. Assumes packed two-digit BCD values.
package bcdcal_pkg;
    localparam int NREG = 8;
    localparam int RW   = 8;
    localparam int IMGW = NREG * RW;

    typedef logic [RW-1:0] bcd8_t;

    // register indices whose position neighbours decode
    localparam int REG_HS   = 0;
    localparam int REG_SEC  = 1;
    localparam int REG_MIN  = 2;
    localparam int REG_HR   = 3;
    localparam int REG_DOW  = 4;
    localparam int REG_DATE = 5;
    localparam int REG_MON  = 6;
    localparam int REG_YR   = 7;

    localparam int STOP_BIT = 5;   // in day register, 1 = frozen
    localparam int MODE_BIT = 7;   // in hours register, 1 = 12-hour
    localparam int PM_BIT   = 5;   // in hours register (12-hour)

    localparam logic [IMGW-1:0] WR_MASK   = 64'hFF_1F_3F_27_BF_7F_7F_FF;
    localparam logic [IMGW-1:0] RESET_IMG = 64'h00_01_01_21_00_00_00_00;

    // Add one to a packed BCD byte (ones digit 9 or above carries)
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Binary value of a packed BCD byte
    function automatic logic [7:0] bcd_to_bin(input bcd8_t v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction
endpackage

// File: rtl/bcd_field_step.sv
// Next-value logic for one BCD field that counts from LO to a limit.
// Assumes the limit is a valid BCD value; a held value at or above the
// limit wraps to LO, so out-of-range loaded values recover on the next step.
module bcd_field_step
    import bcdcal_pkg::*;
#(
    parameter bcd8_t LO = 8'h00
) (
    input  bcd8_t val,
    input  bcd8_t hi,
    input  logic  en,
    output bcd8_t nxt,
    output logic  wrap
);
    // choose hold, wrap to LO, or increment
    always_comb begin
        wrap = en && (val >= hi);
        if (!en)      nxt = val;
        else if (wrap) nxt = LO;
        else          nxt = bcd_inc(val);
    end
endmodule

// File: rtl/hour_step.sv
// Next-value logic for the hours register in either format.
// Bit 7 selects 12-hour counting, bit 5 is PM there or the 20s digit in
// 24-hour counting. Bit 6 always reads 0. Emits a day carry at midnight.
module hour_step
    import bcdcal_pkg::*;
(
    input  bcd8_t hr,
    input  logic  en,
    output bcd8_t nxt,
    output logic  day_carry
);
    bcd8_t v12, v24, inc12, inc24;

    assign v12   = {3'b000, hr[4:0]};
    assign v24   = {2'b00, hr[5:0]};
    assign inc12 = bcd_inc(v12);
    assign inc24 = bcd_inc(v24);

    // advance the hour and decide the midnight carry
    always_comb begin
        nxt       = hr;
        day_carry = 1'b0;
        if (en) begin
            if (hr[MODE_BIT]) begin
                if (v12 == 8'h11) begin
                    nxt       = {1'b1, 1'b0, ~hr[PM_BIT], 5'h12};
                    day_carry = hr[PM_BIT];
                end else if (v12 >= 8'h12) begin
                    nxt = {1'b1, 1'b0, hr[PM_BIT], 5'h01};
                end else begin
                    nxt = {1'b1, 1'b0, hr[PM_BIT], inc12[4:0]};
                end
            end else begin
                if (v24 >= 8'h23) begin
                    nxt       = 8'h00;
                    day_carry = 1'b1;
                end else begin
                    nxt = {2'b00, inc24[5:0]};
                end
            end
        end
    end
endmodule

// File: rtl/month_length.sv
// Last date of a month in BCD, given BCD month and two-digit BCD year.
// Assumes a year divisible by 4 is a leap year (00 included).
module month_length
    import bcdcal_pkg::*;
(
    input  bcd8_t mon,
    input  bcd8_t yr,
    output bcd8_t last
);
    logic [7:0] yr_bin;
    logic       leap;

    assign yr_bin = bcd_to_bin(yr);
    assign leap   = (yr_bin[1:0] == 2'b00);

    // month-length lookup
    always_comb begin
        case (mon)
            8'h02:                      last = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last = 8'h30;
            default:                    last = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
// Top: eight-register BCD time/calendar counter advanced by a 100 Hz tick.
// The carry chain ripples combinationally so a whole rollover lands on one
// edge. Assumes tick is a single-cycle strobe; load replaces the full image.
module bcd_calendar
    import bcdcal_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic [IMGW-1:0] load_img,
    output logic [IMGW-1:0] img
);
    logic [NREG-1:0][RW-1:0] regs;
    bcd8_t hs_n, sec_n, min_n, hr_n, dow_n, date_n, mon_n, yr_n, last_day;
    logic  run, c_sec, c_min, c_hr, c_day, c_dow_unused, c_mon, c_yr, c_yr_unused;

    assign run = tick && !regs[REG_DOW][STOP_BIT];

    bcd_field_step #(.LO(8'h00)) u_hs (
        .val(regs[REG_HS]),  .hi(8'h99), .en(run),   .nxt(hs_n),  .wrap(c_sec));
    bcd_field_step #(.LO(8'h00)) u_sec (
        .val(regs[REG_SEC]), .hi(8'h59), .en(c_sec), .nxt(sec_n), .wrap(c_min));
    bcd_field_step #(.LO(8'h00)) u_min (
        .val(regs[REG_MIN]), .hi(8'h59), .en(c_min), .nxt(min_n), .wrap(c_hr));

    hour_step u_hr (.hr(regs[REG_HR]), .en(c_hr), .nxt(hr_n), .day_carry(c_day));

    bcd_field_step #(.LO(8'h01)) u_dow (
        .val({5'b00000, regs[REG_DOW][2:0]}), .hi(8'h07), .en(c_day),
        .nxt(dow_n), .wrap(c_dow_unused));

    month_length u_len (.mon(regs[REG_MON]), .yr(regs[REG_YR]), .last(last_day));

    bcd_field_step #(.LO(8'h01)) u_date (
        .val(regs[REG_DATE]), .hi(last_day), .en(c_day), .nxt(date_n), .wrap(c_mon));
    bcd_field_step #(.LO(8'h01)) u_mon (
        .val(regs[REG_MON]), .hi(8'h12), .en(c_mon), .nxt(mon_n), .wrap(c_yr));
    bcd_field_step #(.LO(8'h00)) u_yr (
        .val(regs[REG_YR]), .hi(8'h99), .en(c_yr), .nxt(yr_n), .wrap(c_yr_unused));

    // register image: reset, whole-image load, or one counting step
    always_ff @(posedge clk) begin
        if (!rst_n)      regs <= RESET_IMG;
        else if (load)   regs <= load_img & WR_MASK;
        else if (run)    regs <= {yr_n, mon_n, date_n, {5'b00000, dow_n[2:0]},
                                  hr_n, min_n, sec_n, hs_n};
    end

    assign img = regs;

    // R2
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (img == ($past(load_img) & WR_MASK)));
    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && img[8*REG_DOW+STOP_BIT]) |=> $stable(img));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(img));
    // R4
    sec_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && img[7:0] < 8'h99) |=> $stable(img[15:8]));
    // R6
    hour_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(img[8*REG_HR+MODE_BIT]));
endmodule

// File: tb/test_bcd_calendar.sv
`timescale 1ns/1ps
module test_bcd_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [63:0] load_img = '0;
    logic [63:0] img;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar i_bcd_calendar (.clk(clk), .rst_n(rst_n), .tick(tick),
        .load(load), .load_img(load_img), .img(img));

    typedef struct packed {
        logic [63:0] start;
        logic [63:0] expect_img;
        logic [7:0]  req;
    } vec_t;

    // byte order in literals: year_month_date_day_hours_min_sec_hundredths
    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{64'h24_03_15_03_10_20_30_41, 64'h24_03_15_03_10_20_30_42, 8'd3},  // R3
        '{64'h24_03_15_03_10_20_30_99, 64'h24_03_15_03_10_20_31_00, 8'd4},  // R4
        '{64'h24_03_15_03_10_20_59_99, 64'h24_03_15_03_10_21_00_00, 8'd4},  // R4
        '{64'h24_03_15_03_10_59_59_99, 64'h24_03_15_03_11_00_00_00, 8'd4},  // R4
        '{64'h24_03_15_03_23_59_59_99, 64'h24_03_16_04_00_00_00_00, 8'd5},  // R5
        '{64'h24_03_15_03_19_59_59_99, 64'h24_03_15_03_20_00_00_00, 8'd5},  // R5
        '{64'h24_03_15_03_91_59_59_99, 64'h24_03_15_03_B2_00_00_00, 8'd6},  // R6
        '{64'h24_03_15_03_B2_59_59_99, 64'h24_03_15_03_A1_00_00_00, 8'd6},  // R6
        '{64'h24_03_15_03_B1_59_59_99, 64'h24_03_16_04_92_00_00_00, 8'd6},  // R6
        '{64'h24_03_15_03_92_59_59_99, 64'h24_03_15_03_81_00_00_00, 8'd6},  // R6
        '{64'h24_03_15_03_89_59_59_99, 64'h24_03_15_03_90_00_00_00, 8'd6},  // R6
        '{64'h24_03_15_07_23_59_59_99, 64'h24_03_16_01_00_00_00_00, 8'd7},  // R7
        '{64'h24_04_30_02_23_59_59_99, 64'h24_05_01_03_00_00_00_00, 8'd8},  // R8
        '{64'h23_01_31_02_23_59_59_99, 64'h23_02_01_03_00_00_00_00, 8'd8},  // R8
        '{64'h23_01_30_02_23_59_59_99, 64'h23_01_31_03_00_00_00_00, 8'd8},  // R8
        '{64'h24_11_30_02_23_59_59_99, 64'h24_12_01_03_00_00_00_00, 8'd8},  // R8
        '{64'h23_02_28_02_23_59_59_99, 64'h23_03_01_03_00_00_00_00, 8'd9},  // R9
        '{64'h24_02_28_02_23_59_59_99, 64'h24_02_29_03_00_00_00_00, 8'd9},  // R9
        '{64'h24_02_29_02_23_59_59_99, 64'h24_03_01_03_00_00_00_00, 8'd9},  // R9
        '{64'h00_02_28_02_23_59_59_99, 64'h00_02_29_03_00_00_00_00, 8'd9},  // R9
        '{64'h12_02_28_02_23_59_59_99, 64'h12_02_29_03_00_00_00_00, 8'd9},  // R9
        '{64'h10_02_28_02_23_59_59_99, 64'h10_03_01_03_00_00_00_00, 8'd9},  // R9
        '{64'h19_12_31_02_23_59_59_99, 64'h20_01_01_03_00_00_00_00, 8'd10}, // R10
        '{64'h99_12_31_02_23_59_59_99, 64'h00_01_01_03_00_00_00_00, 8'd10}  // R10
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: img=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] v);
        @(negedge clk); load = 1'b1; load_img = v;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: all requirements, actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset image
        check("R1", img, 64'h00_01_01_21_00_00_00_00);
        // R3 stopped after reset: ticks ignored
        do_ticks(3);
        check("R3", img, 64'h00_01_01_21_00_00_00_00);

        // vector table: load, one tick, compare whole image
        for (int i = 0; i < NV; i++) begin
            do_load(VECS[i].start);
            do_ticks(1);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), img, VECS[i].expect_img);
        end

        // R2 masking of unused bits
        do_load(64'hFF_FF_FF_FF_FF_FF_FF_FF);
        check("R2 mask", img, 64'hFF_1F_3F_27_BF_7F_7F_FF);
        // R3 stop bit set (bit 5 of day register) freezes counting
        do_ticks(4);
        check("R3 stop", img, 64'hFF_1F_3F_27_BF_7F_7F_FF);

        // R2 load wins over a tick in the same cycle
        @(negedge clk); load = 1'b1; tick = 1'b1; load_img = 64'h24_06_10_02_08_30_00_50;
        @(negedge clk); load = 1'b0; tick = 1'b0;
        check("R2 priority", img, 64'h24_06_10_02_08_30_00_50);

        // R3 no tick: image stays put
        repeat (5) @(negedge clk);
        check("R3 idle", img, 64'h24_06_10_02_08_30_00_50);

        // R4 one hundred ticks make one second
        do_load(64'h00_01_01_01_00_00_00_00);
        do_ticks(100);
        check("R4 100 ticks", img, 64'h00_01_01_01_00_00_01_00);

        // R3 clearing the stop bit via reload restarts counting
        do_load(64'h00_01_01_21_00_00_00_00);
        do_ticks(2);
        check("R3 stopped", img, 64'h00_01_01_21_00_00_00_00);
        do_load(64'h00_01_01_01_00_00_00_00);
        do_ticks(2);
        check("R3 running", img, 64'h00_01_01_01_00_00_00_02);

        // R1 reset mid-run restores the reset image
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 rerun", img, 64'h00_01_01_21_00_00_00_00);

        done = 1'b1;
        finish_run();
    end
endmodule